// File: doc/BRIEF.md
# Self-Timed Page Erase Sequencer

This block sits behind a byte-level I2C target front end and owns a single erase control register. The front end hands it decoded register writes (address, data and a strobe), register read addresses, and a one-cycle strobe for each STOP condition. Writing the register with its enable bit set only arms an erase. The erase starts when the STOP condition that closes the bus transaction arrives.

When the erase starts, the block sends a one-cycle erase strobe to the nonvolatile array, together with a region select and a 4-bit page index. Each page holds 16 bytes. It then holds `busy` high for a fixed number of clock cycles, which stands in for the array's self-timed erase (at most 20 ms). While `busy` is high the front end refuses bus access, and the block also drops any register write or read. When the interval ends, hardware clears the enable bit.

Top module: `page_erase_seq`

## Requirements
- R1: While reset is asserted, and in the first cycles after it is released, `busy` and `erase_stb` are 0 and the register reads 0x00.
- R2: A write strobe with `wr_addr` equal to `REG_ADDR` (0xE3) while not busy loads the register. Bit 7 is the enable, bits 4..0 are the page select, and bits 6 and 5 always read 0. A read at `REG_ADDR` returns the value written ANDed with 0x9F. A read at any other address returns 0.
- R3: A write strobe to any address other than `REG_ADDR` leaves the register unchanged.
- R4: Writing the enable bit does not start an erase. If the enable is set when `stop_stb` is sampled and the block is idle, then in the next cycle `erase_stb` is high for exactly one cycle and `busy` rises in that same cycle.
- R5: While `erase_stb` is high, `erase_region` equals page-select bit 4 (0 = configuration region, 1 = emulated EEPROM region) and `erase_page` equals bits 3..0. Both stay stable for the whole busy interval.
- R6: `busy` stays high for exactly `ERASE_CYCLES` consecutive cycles for each erase.
- R7: When `busy` falls, the enable bit reads 0 and the page select keeps its value.
- R8: A `stop_stb` with the enable bit at 0 starts no erase, so `busy` and `erase_stb` stay 0.
- R9: Register writes and `stop_stb` pulses that arrive while busy are dropped. They neither change the register nor start or extend an erase.
- R10: While busy, a read at any address returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_stb | input | 1 | One-cycle strobe for a received data byte |
| wr_addr | input | 8 | Register address of the write |
| wr_data | input | 8 | Data byte of the write |
| rd_addr | input | 8 | Register address being read |
| rd_data | output | 8 | Read data for `rd_addr` |
| stop_stb | input | 1 | One-cycle strobe for a bus STOP condition |
| busy | output | 1 | Self-timed erase in progress |
| erase_stb | output | 1 | One-cycle erase request to the array |
| erase_region | output | 1 | Region of the page being erased |
| erase_page | output | 4 | Page index within the region |

## Verification
The bench writes all 256 data values to the register and follows each with a STOP. A design that let bits 6 and 5 through, mixed up the region bit with the page index, or started an erase from the data byte instead of from the STOP would show a wrong readback or a wrong erase strobe. The busy interval is counted cycle by cycle. An off-by-one in the timer shows up as a wrong length, and a missing self-clear shows up as an enable still set when busy falls. The bench also writes every other address, and sends writes and STOPs during an erase. A design that decoded the address loosely, accepted writes while busy, or restarted on a late STOP would corrupt the register or stretch busy.

// File: rtl/erase_pkg.sv
package erase_pkg;
  localparam int CTL_W      = 8;
  localparam int EN_BIT     = 7;
  localparam int REGION_BIT = 4;
  localparam int IDX_W      = 4;
  // bits 6..5 are unused and held at zero
  localparam logic [CTL_W-1:0] CTL_MASK = 8'h9F;
endpackage

// File: rtl/erase_ctl_reg.sv
module erase_ctl_reg
  import erase_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld_en,
  input  logic [CTL_W-1:0] ld_data,
  input  logic             clr_en,
  output logic [CTL_W-1:0] ctl_q
);
  logic [CTL_W-1:0] ctl_d;
  logic             ce;

  always_comb begin
    ctl_d = ctl_q;
    if (ld_en) begin
      ctl_d = ld_data & CTL_MASK;
    end else if (clr_en) begin
      ctl_d[EN_BIT] = 1'b0;
    end
  end

  assign ce = ld_en | clr_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q <= '0;
    end else if (ce) begin
      ctl_q <= ctl_d;
    end
  end
endmodule

// File: rtl/erase_timer.sv
module erase_timer #(
  parameter int unsigned ERASE_CYCLES = 2_000_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic done
);
  localparam int CW = (ERASE_CYCLES > 1) ? $clog2(ERASE_CYCLES) : 1;
  localparam logic [CW-1:0] LOAD = CW'(ERASE_CYCLES - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          busy_d;
  logic          ce;

  assign done = busy & (cnt_q == '0);

  always_comb begin
    cnt_d  = cnt_q;
    busy_d = busy;
    if (start && !busy) begin
      cnt_d  = LOAD;
      busy_d = 1'b1;
    end else if (busy) begin
      if (done) begin
        busy_d = 1'b0;
      end else begin
        cnt_d = cnt_q - 1'b1;
      end
    end
  end

  assign ce = start | busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      busy  <= 1'b0;
    end else if (ce) begin
      cnt_q <= cnt_d;
      busy  <= busy_d;
    end
  end
endmodule

// File: rtl/page_erase_seq.sv
module page_erase_seq
  import erase_pkg::*;
#(
  parameter logic [7:0]  REG_ADDR     = 8'hE3,
  parameter int unsigned ERASE_CYCLES = 2_000_000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_stb,
  input  logic [7:0] wr_addr,
  input  logic [7:0] wr_data,
  input  logic [7:0] rd_addr,
  output logic [7:0] rd_data,
  input  logic       stop_stb,
  output logic       busy,
  output logic       erase_stb,
  output logic       erase_region,
  output logic [3:0] erase_page
);
  logic [1:0]       rst_pipe;
  logic             rst_core_n;
  logic [CTL_W-1:0] ctl_q;
  logic             wr_hit;
  logic             launch;
  logic             done;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= 2'b00;
    end else begin
      rst_pipe <= {rst_pipe[0], 1'b1};
    end
  end
  assign rst_core_n = rst_pipe[1];

  assign wr_hit = wr_stb & (wr_addr == REG_ADDR) & ~busy;
  assign launch = stop_stb & ctl_q[EN_BIT] & ~busy;

  erase_ctl_reg u_reg (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .ld_en   (wr_hit),
    .ld_data (wr_data),
    .clr_en  (done),
    .ctl_q   (ctl_q)
  );

  erase_timer #(.ERASE_CYCLES(ERASE_CYCLES)) u_tmr (
    .clk   (clk),
    .rst_n (rst_core_n),
    .start (launch),
    .busy  (busy),
    .done  (done)
  );

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      erase_stb <= 1'b0;
    end else begin
      erase_stb <= launch;
    end
  end

  assign erase_region = ctl_q[REGION_BIT];
  assign erase_page   = ctl_q[IDX_W-1:0];

  assign rd_data = (!busy && rd_addr == REG_ADDR) ? ctl_q : '0;
endmodule

// File: rtl/erase_seq_chk.sv
module erase_seq_chk #(
  parameter logic [7:0]  REG_ADDR     = 8'hE3,
  parameter int unsigned ERASE_CYCLES = 2_000_000
) (
  input logic       clk,
  input logic       rst_n,
  input logic       stop_stb,
  input logic [7:0] rd_addr,
  input logic [7:0] rd_data,
  input logic       busy,
  input logic       erase_stb,
  input logic       erase_region,
  input logic [3:0] erase_page
);
  int unsigned run_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_len <= 0;
    end else if (busy) begin
      run_len <= run_len + 1;
    end else begin
      run_len <= 0;
    end
  end

  p_stb_on_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> erase_stb);
  p_stb_only_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
    erase_stb |-> $rose(busy));
  p_stb_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    erase_stb |=> !erase_stb);
  p_needs_stop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(stop_stb));
  p_target_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ($stable(erase_page) && $stable(erase_region)));
  p_busy_len_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (run_len == ERASE_CYCLES));
  p_self_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(busy) && rd_addr == REG_ADDR) |-> !rd_data[7]);
  p_busy_read_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (rd_data == 8'h00));
  p_unused_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[6:5] == 2'b00);
endmodule

bind page_erase_seq erase_seq_chk #(
  .REG_ADDR     (REG_ADDR),
  .ERASE_CYCLES (ERASE_CYCLES)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .stop_stb     (stop_stb),
  .rd_addr      (rd_addr),
  .rd_data      (rd_data),
  .busy         (busy),
  .erase_stb    (erase_stb),
  .erase_region (erase_region),
  .erase_page   (erase_page)
);

// File: tb/sim_page_erase_seq.sv
`timescale 1ns/1ps
module sim_page_erase_seq;
  localparam logic [7:0] ADDR = 8'hE3;
  localparam int         NCYC = 5;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_stb = 1'b0;
  logic [7:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_addr = ADDR;
  logic [7:0] rd_data;
  logic       stop_stb = 1'b0;
  logic       busy, erase_stb, erase_region;
  logic [3:0] erase_page;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  page_erase_seq #(.REG_ADDR(ADDR), .ERASE_CYCLES(NCYC)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .stop_stb(stop_stb), .busy(busy), .erase_stb(erase_stb),
    .erase_region(erase_region), .erase_page(erase_page)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    wr_stb = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_stb = 1'b0;
  endtask

  task automatic stop;
    stop_stb = 1'b1;
    @(negedge clk);
    stop_stb = 1'b0;
  endtask

  // after a launch was observed: count busy cycles including the current one
  task automatic count_busy(output int len);
    len = 1;
    for (int k = 0; k < 4 * NCYC; k++) begin
      @(negedge clk);
      chk(erase_stb == 1'b0, "R4 strobe single", erase_stb, 0);
      if (!busy) break;
      len++;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    int len;
    logic [7:0] exp_rd;
    repeat (3) @(negedge clk);
    chk(busy == 0 && erase_stb == 0, "R1 outputs in reset", {busy, erase_stb}, 0);
    chk(rd_data == 8'h00, "R1 register in reset", rd_data, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(busy == 0 && erase_stb == 0 && rd_data == 0, "R1 after release",
        {busy, erase_stb, rd_data}, 0);

    // R3: every other address ignored; R8: stop with nothing pending
    for (int a = 0; a < 256; a++) begin
      if (a[7:0] == ADDR) continue;
      wr(a[7:0], 8'hFF);
      chk(rd_data == 8'h00, "R3 foreign write", rd_data, 0);
      stop();
      chk(busy == 0 && erase_stb == 0, "R8 stop without enable", {busy, erase_stb}, 0);
    end

    // exhaustive data sweep: R2 R4 R5 R6 R7 R8
    for (int d = 0; d < 256; d++) begin
      exp_rd = d[7:0] & 8'h9F;
      wr(ADDR, d[7:0]);
      chk(rd_data == exp_rd, "R2 readback", rd_data, exp_rd);
      chk(busy == 0 && erase_stb == 0, "R4 no erase on data byte", {busy, erase_stb}, 0);
      rd_addr = 8'h12;
      #1;
      chk(rd_data == 8'h00, "R2 other read address", rd_data, 0);
      rd_addr = ADDR;
      stop();
      if (d[7]) begin
        chk(erase_stb == 1 && busy == 1, "R4 launch on stop", {erase_stb, busy}, 3);
        chk(erase_region == d[4], "R5 region", erase_region, d[4]);
        chk(erase_page == d[3:0], "R5 page", erase_page, d[3:0]);
        chk(rd_data == 8'h00, "R10 read while busy", rd_data, 0);
        count_busy(len);
        chk(len == NCYC, "R6 busy length", len, NCYC);
        chk(rd_data == (exp_rd & 8'h1F), "R7 enable self-clear", rd_data, exp_rd & 8'h1F);
      end else begin
        chk(erase_stb == 0 && busy == 0, "R8 enable low", {erase_stb, busy}, 0);
        chk(rd_data == exp_rd, "R8 register kept", rd_data, exp_rd);
      end
    end

    // R9: writes and stops during the interval are dropped
    wr(ADDR, 8'h95);
    stop();
    chk(erase_stb == 1 && busy == 1, "R9 launch", {erase_stb, busy}, 3);
    len = 1;
    wr(ADDR, 8'h8A);
    len += busy;
    stop();
    len += busy;
    while (busy && len < 4 * NCYC) begin
      @(negedge clk);
      len += busy;
    end
    chk(len == NCYC, "R9 interval not extended", len, NCYC);
    chk(rd_data == 8'h15, "R9 write while busy dropped", rd_data, 8'h15);
    repeat (2) @(negedge clk);
    chk(busy == 0 && erase_stb == 0, "R9 no restart", {busy, erase_stb}, 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule